// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block multiplies two 32-bit operand words element by element, sums the products and adds the total to an accumulator value that arrives with the operands. One mode input picks how each word is split: four 8-bit elements, eight 4-bit elements or sixteen 2-bit elements. Each time the element width halves, the number of products formed per accepted operation doubles, and the datapath stays the same width. A second input treats the elements as two's-complement or as unsigned. A third input picks a 32-bit accumulation or a 16-bit accumulation that wraps and is sign-extended onto the 32-bit result.

Operations enter and leave through valid/ready handshakes. The pipeline has three register stages: element extraction and multiplication, a balanced adder tree, and the final add. A new operation can enter every cycle. When the consumer withholds ready, the whole pipeline freezes and the input side stops accepting.

Top module: `mpdot_unit`

## Requirements
- R1: With `elem_mode` = 0, the block reads four 8-bit element pairs. Element i occupies bits [8i+7:8i] of each word, and the dot product is the sum of a_i*b_i.
- R2: With `elem_mode` = 1, the block reads eight 4-bit element pairs. Element i occupies bits [4i+3:4i].
- R3: With `elem_mode` = 2, the block reads sixteen 2-bit element pairs. Element i occupies bits [2i+1:2i].
- R4: With `elem_signed` = 1, each element is read as two's complement. With `elem_signed` = 0, each element is read as unsigned.
- R5: With `acc_narrow` = 0, `result` equals (`acc_in` + dot product) mod 2^32.
- R6: With `acc_narrow` = 1, `result[15:0]` equals (`acc_in[15:0]` + dot product) mod 2^16, and `result[31:16]` are all copies of `result[15]`.
- R7: The value `elem_mode` = 3 behaves exactly like the 8-bit mode.
- R8: While `out_ready` is high, an operation accepted at clock edge k appears with `out_valid` high after edge k+2. Operations accepted on consecutive edges leave on consecutive edges, in order.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `result` stay unchanged on the next edge.
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: A cycle with no accepted input produces no output. `out_valid` rises only for operations that were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are present |
| in_ready | output | 1 | Block accepts an operation on this edge |
| a_word | input | 32 | Packed first operand |
| b_word | input | 32 | Packed second operand |
| acc_in | input | 32 | Accumulator value added to the dot product |
| elem_mode | input | 2 | Element width: 0 = 8-bit, 1 = 4-bit, 2 = 2-bit, 3 = 8-bit |
| elem_signed | input | 1 | 1 = two's-complement elements, 0 = unsigned |
| acc_narrow | input | 1 | 1 = 16-bit wrapping accumulation, 0 = 32-bit |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| result | output | 32 | Accumulated dot product |

## Verification
Acceptance of a new operation and delivery of an older result can happen on the same edge. Holding back a result can also coincide with an operation waiting at the input. The bench provokes both by randomising `in_valid` and `out_ready` independently on every cycle, across every combination of width, signedness and accumulation mode. Each accepted operation is queued together with an arithmetically computed expected value. Each transfer pops and compares one entry. A stalled cycle must show the same result on the following cycle, with the input side refusing new work.

// File: rtl/mpdot_pkg.sv
package mpdot_pkg;

  typedef enum logic [1:0] {
    MODE_B8  = 2'd0,
    MODE_B4  = 2'd1,
    MODE_B2  = 2'd2,
    MODE_RSV = 2'd3
  } elem_mode_e;

  // Fold the spare encoding onto the byte mode
  function automatic elem_mode_e norm_mode(input logic [1:0] m);
    elem_mode_e r;
    case (m)
      2'd1:    r = MODE_B4;
      2'd2:    r = MODE_B2;
      default: r = MODE_B8;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mpdot_unpack_mul.sv
module mpdot_unpack_mul
  import mpdot_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PW     = 18
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  elem_mode_e                  mode,
  input  logic                        sgn,
  input  logic [WORD_W-1:0]           a,
  input  logic [WORD_W-1:0]           b,
  output logic [WORD_W/2-1:0][PW-1:0] prod_q
);
  localparam int N8 = WORD_W / 8;
  localparam int N4 = WORD_W / 4;
  localparam int N2 = WORD_W / 2;

  logic signed [PW-1:0] p8 [N8];
  logic signed [PW-1:0] p4 [N4];
  logic signed [PW-1:0] p2 [N2];

  // One extension bit per element: sign copy or zero
  for (genvar g = 0; g < N8; g++) begin : g_b8
    logic signed [8:0] ea, eb;
    assign ea = {sgn & a[8*g+7], a[8*g +: 8]};
    assign eb = {sgn & b[8*g+7], b[8*g +: 8]};
    assign p8[g] = PW'(ea) * PW'(eb);
  end

  for (genvar g = 0; g < N4; g++) begin : g_b4
    logic signed [4:0] ea, eb;
    assign ea = {sgn & a[4*g+3], a[4*g +: 4]};
    assign eb = {sgn & b[4*g+3], b[4*g +: 4]};
    assign p4[g] = PW'(ea) * PW'(eb);
  end

  for (genvar g = 0; g < N2; g++) begin : g_b2
    logic signed [2:0] ea, eb;
    assign ea = {sgn & a[2*g+1], a[2*g +: 2]};
    assign eb = {sgn & b[2*g+1], b[2*g +: 2]};
    assign p2[g] = PW'(ea) * PW'(eb);
  end

  logic [N2-1:0][PW-1:0] nxt;

  always_comb begin
    nxt = '0;
    case (mode)
      MODE_B4: for (int i = 0; i < N4; i++) nxt[i] = p4[i];
      MODE_B2: for (int i = 0; i < N2; i++) nxt[i] = p2[i];
      default: for (int i = 0; i < N8; i++) nxt[i] = p8[i];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     prod_q <= '0;
    else if (en) prod_q <= nxt;
  end

endmodule

// File: rtl/mpdot_tree.sv
module mpdot_tree #(
  parameter int LEAVES = 16,
  parameter int PW     = 18,
  parameter int SUM_W  = PW + $clog2(LEAVES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [LEAVES-1:0][PW-1:0]   prod,
  output logic signed [SUM_W-1:0]     sum_q
);
  localparam int DEPTH = $clog2(LEAVES);

  // Balanced pairwise reduction, one generate level per tree rank
  for (genvar l = 0; l <= DEPTH; l++) begin : lvl
    localparam int CNT = LEAVES >> l;
    logic signed [SUM_W-1:0] v [CNT];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_ext
        assign v[j] = SUM_W'($signed(prod[j]));
      end
    end else begin : g_node
      for (genvar j = 0; j < CNT; j++) begin : g_add
        assign v[j] = lvl[l-1].v[2*j] + lvl[l-1].v[2*j+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     sum_q <= '0;
    else if (en) sum_q <= lvl[DEPTH].v[0];
  end

endmodule

// File: rtl/mpdot_accum.sv
module mpdot_accum #(
  parameter int ACC_W = 32,
  parameter int NAR_W = 16,
  parameter int SUM_W = 22
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    vld,
  input  logic                    nar,
  input  logic [ACC_W-1:0]        acc,
  input  logic signed [SUM_W-1:0] sum,
  output logic                    vld_q,
  output logic [ACC_W-1:0]        res_q
);
  localparam int EXT_W = ACC_W - NAR_W;

  logic [ACC_W-1:0] full;
  logic [ACC_W-1:0] nxt;
  logic             nar_q;

  assign full = acc + ACC_W'(sum);
  assign nxt  = nar ? {{EXT_W{full[NAR_W-1]}}, full[NAR_W-1:0]} : full;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      res_q <= '0;
      nar_q <= 1'b0;
    end else if (en) begin
      vld_q <= vld;
      res_q <= nxt;
      nar_q <= nar;
    end
  end

  // R6
  narrow_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && nar_q) |-> (res_q[ACC_W-1:NAR_W] == {EXT_W{res_q[NAR_W-1]}}));

endmodule

// File: rtl/mpdot_unit.sv
module mpdot_unit
  import mpdot_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ACC_W  = 32,
  parameter int NAR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [1:0]        elem_mode,
  input  logic              elem_signed,
  input  logic              acc_narrow,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  result
);
  localparam int MAX_EW = 8;
  localparam int LEAVES = WORD_W / 2;
  localparam int N8     = WORD_W / MAX_EW;
  localparam int PW     = 2 * (MAX_EW + 1);
  localparam int SUM_W  = PW + $clog2(LEAVES);

  logic en;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  // Sideband travelling alongside the datapath
  logic             s1_valid, s2_valid;
  logic [ACC_W-1:0] s1_acc, s2_acc;
  logic             s1_nar, s2_nar;
  elem_mode_e       s1_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s1_acc   <= '0;
      s2_acc   <= '0;
      s1_nar   <= 1'b0;
      s2_nar   <= 1'b0;
      s1_mode  <= MODE_B8;
    end else if (en) begin
      s1_valid <= in_valid;
      s1_acc   <= acc_in;
      s1_nar   <= acc_narrow;
      s1_mode  <= norm_mode(elem_mode);
      s2_valid <= s1_valid;
      s2_acc   <= s1_acc;
      s2_nar   <= s1_nar;
    end
  end

  logic [LEAVES-1:0][PW-1:0] prod;
  logic signed [SUM_W-1:0]   sum;

  mpdot_unpack_mul #(.WORD_W(WORD_W), .PW(PW)) u_mul (
    .clk(clk), .rst(rst), .en(en),
    .mode(norm_mode(elem_mode)), .sgn(elem_signed),
    .a(a_word), .b(b_word), .prod_q(prod)
  );

  mpdot_tree #(.LEAVES(LEAVES), .PW(PW), .SUM_W(SUM_W)) u_tree (
    .clk(clk), .rst(rst), .en(en), .prod(prod), .sum_q(sum)
  );

  mpdot_accum #(.ACC_W(ACC_W), .NAR_W(NAR_W), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .en(en),
    .vld(s2_valid), .nar(s2_nar), .acc(s2_acc), .sum(sum),
    .vld_q(out_valid), .res_q(result)
  );

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  // R8
  accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> s1_valid);

  // R1
  slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mode == MODE_B8) |-> (prod[LEAVES-1:N8] == '0));

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/tb_mpdot_unit.sv
`timescale 1ns/1ps
module tb_mpdot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] a_word = '0, b_word = '0, acc_in = '0;
  logic [1:0]  elem_mode = '0;
  logic        elem_signed = 1'b0, acc_narrow = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mpdot_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a_word(a_word), .b_word(b_word), .acc_in(acc_in),
    .elem_mode(elem_mode), .elem_signed(elem_signed), .acc_narrow(acc_narrow),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  function automatic longint ref_dot(bit [31:0] a, bit [31:0] b, int m, bit s);
    int w = (m == 1) ? 4 : (m == 2) ? 2 : 8;
    longint acc = 0;
    for (int i = 0; i < 32 / w; i++) begin
      longint ea = longint'((a >> (i * w)) & ((32'd1 << w) - 1));
      longint eb = longint'((b >> (i * w)) & ((32'd1 << w) - 1));
      if (s && ((ea >> (w - 1)) & 1) == 1) ea -= (longint'(1) << w);
      if (s && ((eb >> (w - 1)) & 1) == 1) eb -= (longint'(1) << w);
      acc += ea * eb;
    end
    return acc;
  endfunction

  function automatic bit [31:0] ref_res(bit [31:0] acc, longint d, bit n);
    longint t = longint'(acc) + d;
    bit [63:0] tb = t;
    if (n) return {{16{tb[15]}}, tb[15:0]};
    return tb[31:0];
  endfunction

  task automatic fail(string req, bit [31:0] act, bit [31:0] exp);
    errors++;
    $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  bit [31:0] exp_q[$];
  string     tag_q[$];
  bit        hold_pend = 0;
  bit [31:0] hold_val  = '0;

  // Called after inputs for the coming edge are applied and settled
  task automatic monitor();
    if (hold_pend) begin
      checks++;  // R9 hold
      if (!(out_valid && result == hold_val)) fail("R9", result, hold_val);
    end
    if (out_valid && !out_ready) begin
      checks++;  // R9 input blocked
      if (in_ready) fail("R9", {31'd0, in_ready}, 32'd0);
      hold_pend = 1; hold_val = result;
    end else hold_pend = 0;
    if (out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) fail("R11", result, 32'hxxxxxxxx);
      else begin
        bit [31:0] e = exp_q.pop_front();
        string t = tag_q.pop_front();
        if (result !== e) fail(t, result, e);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  bit [31:0] pat [6] = '{32'h0, 32'hFFFFFFFF, 32'h80808080, 32'h7F7F7F7F,
                         32'hAAAAAAAA, 32'h55555555};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    checks++;  // R10
    if (out_valid !== 1'b0) fail("R10", {31'd0, out_valid}, 32'd0);
    checks++;
    if (in_ready !== 1'b1) fail("R10", {31'd0, in_ready}, 32'd1);

    // R8 latency: single op, 8-bit signed, wide accumulate
    a_word = 32'h01FF0302; b_word = 32'h05040302; acc_in = 32'd100;
    elem_mode = 2'd0; elem_signed = 1; acc_narrow = 0; in_valid = 1; out_ready = 1;
    @(negedge clk); in_valid = 0; #1;
    checks++;
    if (out_valid) fail("R8", {31'd0, out_valid}, 32'd0);
    @(negedge clk); #1;
    checks++;
    if (out_valid) fail("R8", {31'd0, out_valid}, 32'd0);
    @(negedge clk); #1;
    checks++;
    if (!out_valid || result !== ref_res(32'd100, ref_dot(32'h01FF0302, 32'h05040302, 0, 1), 0))
      fail("R8", result, ref_res(32'd100, ref_dot(32'h01FF0302, 32'h05040302, 0, 1), 0));
    @(negedge clk); #1;
    checks++;  // R11 no spurious output
    if (out_valid) fail("R11", {31'd0, out_valid}, 32'd0);

    // Sweep: R1 R2 R3 R4 R5 R6 R7 under random handshakes
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int n = 0; n < 2; n++) begin
          for (int k = 0; k < 266; k++) begin
            bit [31:0] a, b, c;
            if (k < 36) begin a = pat[k % 6]; b = pat[k / 6]; end
            else begin a = $urandom; b = $urandom; end
            c = (k % 3 == 0) ? 32'h00007FFF : (k % 3 == 1) ? 32'hFFFFFFFF : $urandom;
            forever begin
              @(negedge clk);
              out_ready = ($urandom % 4) != 0;
              in_valid  = ($urandom % 5) != 0;
              a_word = a; b_word = b; acc_in = c;
              elem_mode = m[1:0]; elem_signed = s[0]; acc_narrow = n[0];
              #1;
              monitor();
              if (in_valid && in_ready) begin
                exp_q.push_back(ref_res(c, ref_dot(a, b, (m == 3) ? 0 : m, s[0]), n[0]));
                tag_q.push_back(m == 3 ? "R7" : n ? "R6" : m == 1 ? "R2" : m == 2 ? "R3" : "R1");
                break;
              end
            end
          end
        end
      end
    end

    // Drain, then confirm nothing extra appears (R11)
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      in_valid = 0; out_ready = 1;
      #1;
      monitor();
    end
    checks++;
    if (exp_q.size() != 0) fail("R8", exp_q.size(), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule